// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software reach an external one-bit serial EEPROM by toggling its pins from a control register, while the EEPROM shares a memory port with other requesters. Software sets a request bit in the control register. The block keeps waiting while the memory port is busy with another requester. When the port is free, the block takes the port, switches it to the EEPROM and raises a ready bit. From then on, every write to the control register drives chip select, serial clock and data out straight onto the EEPROM pins. The synchronised data-in pin reads back in bit 0.

The ready bit has two uses. The first time it rises, it marks the grant, with no fixed delay. After that, each write to the register while the port is held drops ready. Ready rises again after a fixed settle time, 800 ns by default. Software polls ready to pace its clock edges. The settle time is turned into a clock count from a clock-period parameter.

When software clears the request bit, the port is released, the pins go low and ready clears. Pin values written while the port is not held are stored and read back, but they reach the pins only once the port is granted. Two more bits carry an external arbitration request (written by software) and an external arbitration acknowledge (read from an input pin).

Top module: `seeprom_port_arb`

## Requirements
- R1: After reset, ee_port_sel, ext_arb_req, ee_cs, ee_sk and ee_do are 0, and rd_data bits 6..0 read 0. Bit 7 always reads the ext_arb_ack input.
- R2: Control bit 5 is the port request and reads back as written. The port is granted (ee_port_sel rises) at the first clock edge where the request is already registered and mem_busy is low. While mem_busy stays high, there is no grant.
- R3: Ready (bit 4) rises at the same edge as the grant, with no settle wait.
- R4: A write with bit 5 set while the port is held drops ready from that edge. Ready rises again exactly ceil(SETTLE_PS/CLK_PERIOD_PS) cycles later, which is 40 cycles at the defaults. A new write during the wait restarts the count.
- R5: While the port is held, bits 3, 2 and 1 of a write drive ee_cs, ee_sk and ee_do from that write's clock edge.
- R6: Bit 0 reads ee_di through SYNC_STAGES flops (2 by default) while the port is held. It reads 0 while the port is not held.
- R7: A write with bit 5 clear releases the port at that edge: ee_port_sel, ready and all three pins go to 0.
- R8: Pin bits written while the port is not held are stored and read back on bits 3..1, but the pins stay 0. The stored values appear on the pins at the grant edge.
- R9: Bit 6 is written by software and drives ext_arb_req. Write values on bits 7, 4 and 0 are ignored.
- R10: Once the port is granted, mem_busy has no effect. The port stays held until the request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| mem_busy | input | 1 | Shared memory port is serving another requester |
| ee_port_sel | output | 1 | Memory port switched to EEPROM access |
| ext_arb_req | output | 1 | External arbitration request (bit 6) |
| ext_arb_ack | input | 1 | External arbitration acknowledge (bit 7) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data toward the EEPROM |
| ee_di | input | 1 | Data from the EEPROM |

## Verification
A wrong arbitration state appears at ee_port_sel and ready in the same cycle as the edge that corrupted it. Examples are a grant taken while mem_busy is high, or a grant dropped while the request is still set. A bad settle counter shows up as ready rising too early or too late against a fixed cycle count after each write, so its error surfaces within at most 40 cycles. A faulty pin shadow or grant gate drives a pin while the port is free, or fails to drive it at the grant edge, and this is visible on the pins at once.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   // Control register field positions (software decodes these)
   localparam int unsigned CTL_W    = 8;
   localparam int unsigned BIT_DI   = 0;
   localparam int unsigned BIT_DO   = 1;
   localparam int unsigned BIT_SK   = 2;
   localparam int unsigned BIT_CS   = 3;
   localparam int unsigned BIT_RDY  = 4;
   localparam int unsigned BIT_REQ  = 5;
   localparam int unsigned BIT_XREQ = 6;
   localparam int unsigned BIT_XACK = 7;

   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_WAIT = 2'd1,
      ARB_OWN  = 2'd2
   } arb_state_e;

   typedef struct packed {
      logic cs;
      logic sk;
      logic dout;
   } pin_set_t;
endpackage

// File: rtl/seeprom_arb_fsm.sv
module seeprom_arb_fsm
   import seeprom_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_req,
   input  logic mem_busy,
   output logic req_q,
   output logic grant_q,
   output logic grant_nxt
);
   arb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_en && !wr_req) begin
         state_d = ARB_IDLE;
      end else begin
         unique case (state_q)
            ARB_IDLE: if (wr_en && wr_req) state_d = ARB_WAIT;
            ARB_WAIT: if (!mem_busy)       state_d = ARB_OWN;
            ARB_OWN:                       state_d = ARB_OWN;
            default:                       state_d = ARB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign req_q     = (state_q != ARB_IDLE);
   assign grant_q   = (state_q == ARB_OWN);
   assign grant_nxt = (state_d == ARB_OWN);
endmodule

// File: rtl/seeprom_settle_timer.sv
module seeprom_settle_timer #(
   parameter int unsigned SETTLE_CYC = 40,
   parameter int unsigned CNT_W      = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic restart,
   output logic busy
);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clear)           cnt_q <= '0;
      else if (restart)         cnt_q <= LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/seeprom_pin_drv.sv
module seeprom_pin_drv
   import seeprom_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  pin_set_t wr_pins,
   input  logic     grant_nxt,
   input  logic     ee_di,
   output pin_set_t shadow_q,
   output pin_set_t pins_q,
   output logic     di_sync
);
   pin_set_t shadow_d;

   assign shadow_d = wr_en ? wr_pins : shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         pins_q   <= '0;
      end else begin
         shadow_q <= shadow_d;
         pins_q   <= grant_nxt ? shadow_d : '0;
      end
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign di_sync = ee_di;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], ee_di};
         end
         assign di_sync = chain_q[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/seeprom_port_arb.sv
module seeprom_port_arb
   import seeprom_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 20000,
   parameter int unsigned SETTLE_PS     = 800000,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       mem_busy,
   output logic       ee_port_sel,
   output logic       ext_arb_req,
   input  logic       ext_arb_ack,
   output logic       ee_cs,
   output logic       ee_sk,
   output logic       ee_do,
   input  logic       ee_di
);
   localparam int unsigned SETTLE_CYC = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
   localparam int unsigned CNT_W      = $clog2(SETTLE_CYC + 1);

   initial begin
      if (CLK_PERIOD_PS == 0) $error("CLK_PERIOD_PS must be non-zero");
      if (SETTLE_CYC < 1)     $error("settle time must cover at least one cycle");
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) $error("SYNC_STAGES must be 0, 2, 3 or 4");
   end

   logic     req_q, grant_q, grant_nxt, timer_busy, di_sync, xreq_q;
   pin_set_t wr_pins, shadow_q, pins_q;

   assign wr_pins = '{cs: wr_data[BIT_CS], sk: wr_data[BIT_SK], dout: wr_data[BIT_DO]};

   seeprom_arb_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_req    (wr_data[BIT_REQ]),
      .mem_busy  (mem_busy),
      .req_q     (req_q),
      .grant_q   (grant_q),
      .grant_nxt (grant_nxt)
   );

   seeprom_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!grant_nxt),
      .restart (wr_en && grant_q && wr_data[BIT_REQ]),
      .busy    (timer_busy)
   );

   seeprom_pin_drv #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_pins   (wr_pins),
      .grant_nxt (grant_nxt),
      .ee_di     (ee_di),
      .shadow_q  (shadow_q),
      .pins_q    (pins_q),
      .di_sync   (di_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     xreq_q <= 1'b0;
      else if (wr_en) xreq_q <= wr_data[BIT_XREQ];
   end

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_XACK] = ext_arb_ack;
      rd_data[BIT_XREQ] = xreq_q;
      rd_data[BIT_REQ]  = req_q;
      rd_data[BIT_RDY]  = grant_q && !timer_busy;
      rd_data[BIT_CS]   = shadow_q.cs;
      rd_data[BIT_SK]   = shadow_q.sk;
      rd_data[BIT_DO]   = shadow_q.dout;
      rd_data[BIT_DI]   = grant_q && di_sync;
   end

   assign ee_port_sel = grant_q;
   assign ext_arb_req = xreq_q;
   assign ee_cs       = pins_q.cs;
   assign ee_sk       = pins_q.sk;
   assign ee_do       = pins_q.dout;
endmodule

// File: rtl/seeprom_port_arb_chk.sv
module seeprom_port_arb_chk #(
   parameter int unsigned SETTLE_CYC = 40,
   parameter int unsigned CNT_W      = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       mem_busy,
   input logic       ee_port_sel,
   input logic       ee_cs,
   input logic       ee_sk,
   input logic       ee_do
);
   logic [CNT_W-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    hold_cnt <= '0;
      else if (wr_en && !wr_data[5])                 hold_cnt <= '0;
      else if (wr_en && ee_port_sel)                 hold_cnt <= CNT_W'(SETTLE_CYC);
      else if (hold_cnt != '0)                       hold_cnt <= hold_cnt - 1'b1;
   end

   AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_port_sel) |-> $past(!mem_busy)); // R2
   AST_READY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_port_sel) |-> rd_data[4]); // R3
   AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cnt != '0) |-> !rd_data[4]); // R4
   AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ee_port_sel && wr_data[5]) |=>
      (ee_cs == $past(wr_data[3]) && ee_sk == $past(wr_data[2]) && ee_do == $past(wr_data[1]))); // R5
   AST_DI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_port_sel |-> !rd_data[0]); // R6
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[5]) |=> (!ee_port_sel && !rd_data[4])); // R7
   AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_port_sel |-> !(ee_cs || ee_sk || ee_do)); // R8
   AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_port_sel && !(wr_en && !wr_data[5])) |=> ee_port_sel); // R10
endmodule

bind seeprom_port_arb seeprom_port_arb_chk #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .mem_busy    (mem_busy),
   .ee_port_sel (ee_port_sel),
   .ee_cs       (ee_cs),
   .ee_sk       (ee_sk),
   .ee_do       (ee_do)
);

// File: tb/seeprom_port_arb_tb.sv
module seeprom_port_arb_tb;
   localparam int SETTLE = 800000 / 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       mem_busy = 1'b0;
   logic       ee_port_sel, ext_arb_req;
   logic       ext_arb_ack = 1'b0;
   logic       ee_cs, ee_sk, ee_do;
   logic       ee_di = 1'b0;

   int    vectors = 0;
   int    miscompares = 0;
   int    cycles = 0;
   string phase = "R1";
   bit    done = 1'b0;

   seeprom_port_arb u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .mem_busy(mem_busy), .ee_port_sel(ee_port_sel), .ext_arb_req(ext_arb_req),
      .ext_arb_ack(ext_arb_ack), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
   );

   always #10 clk = ~clk;

   // Behavioural reference model
   bit m_req, m_gr, m_xreq;
   bit [2:0] m_sh, m_pins;
   int m_wait;
   bit m_di [$] = '{1'b0, 1'b0};

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_req = 0; m_gr = 0; m_xreq = 0; m_sh = 0; m_pins = 0; m_wait = 0;
         m_di = '{1'b0, 1'b0};
      end else begin
         bit nreq, ngr;
         nreq = wr_en ? wr_data[5] : m_req;
         if (!nreq)      ngr = 0;
         else if (m_gr)  ngr = 1;
         else            ngr = m_req && !mem_busy;
         if (!ngr)                  m_wait = 0;
         else if (wr_en && m_gr)    m_wait = SETTLE;
         else if (m_wait > 0)       m_wait = m_wait - 1;
         if (wr_en) begin
            m_sh   = wr_data[3:1];
            m_xreq = wr_data[6];
         end
         m_req  = nreq;
         m_gr   = ngr;
         m_pins = ngr ? m_sh : 3'b000;
         m_di.push_back(ee_di);
         void'(m_di.pop_front());
      end
   end

   task automatic check(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit [7:0] exp_rd;
         exp_rd = {ext_arb_ack, m_xreq, m_req, (m_gr && m_wait == 0), m_sh, (m_gr && m_di[0])};
         check({phase, " rd_data"}, rd_data, exp_rd);
         check({phase, " port_sel"}, ee_port_sel, m_gr);
         check({phase, " pins"}, {ee_cs, ee_sk, ee_do}, m_pins);
         check({phase, " ext_req"}, ext_arb_req, m_xreq);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      wait (cycles >= 150000);
      miscompares++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_run();
   end

   initial begin
      int n;
      step(3);
      // R1: reset state
      @(negedge clk);
      check("R1 reset rd", rd_data, 8'h00);
      check("R1 reset pins", {ee_port_sel, ext_arb_req, ee_cs, ee_sk, ee_do}, 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      step(2);

      // R8: pin writes without grant stay off the pins
      phase = "R8";
      mem_busy = 1'b1;
      wr(8'h0E);
      step(1);
      @(negedge clk);
      check("R8 pins quiet", {ee_cs, ee_sk, ee_do}, 0);
      check("R8 readback", rd_data[3:1], 3'b111);

      // R2: request while busy -> no grant
      phase = "R2";
      wr(8'h2E);
      ee_di = 1'b1;
      step(5);
      @(negedge clk);
      check("R2 no grant while busy", ee_port_sel, 0);
      check("R6 di masked", rd_data[0], 0);
      // R9: external ack readback
      phase = "R9";
      ext_arb_ack = 1'b1;
      step(1);
      @(negedge clk);
      check("R9 ack bit7", rd_data[7], 1);

      // R3: grant with immediate ready
      phase = "R3";
      mem_busy = 1'b0;
      step(1);
      @(negedge clk);
      check("R3 grant", ee_port_sel, 1);
      check("R3 ready at once", rd_data[4], 1);
      check("R8 held pins appear", {ee_cs, ee_sk, ee_do}, 3'b111);

      // R10: busy ignored once granted
      phase = "R10";
      mem_busy = 1'b1;
      step(4);
      @(negedge clk);
      check("R10 grant kept", ee_port_sel, 1);

      // R5 + R4: pin write and settle count
      phase = "R4";
      @(posedge clk); #2;
      wr(8'h28);
      n = 0;
      @(negedge clk);
      while (!rd_data[4] && n < 1000) begin
         n++;
         @(negedge clk);
      end
      check("R4 settle cycles", n, SETTLE);
      check("R5 cs only", {ee_cs, ee_sk, ee_do}, 3'b100);

      // R6: data-in sampled through synchroniser
      phase = "R6";
      @(posedge clk); #2;
      ee_di = 1'b0;
      step(3);
      ee_di = 1'b1;
      step(1);
      ee_di = 1'b0;
      step(4);

      // R4: restart during wait
      phase = "R4";
      wr(8'h2C);
      step(10);
      wr(8'h2A);
      step(SETTLE - 1);
      @(negedge clk);
      check("R4 still waiting after restart", rd_data[4], 0);
      step(2);

      // R9: bits 7,4,0 ignored, bit6 drives ext request
      phase = "R9";
      wr(8'hFF);
      @(negedge clk);
      check("R9 ext req", ext_arb_req, 1);
      check("R9 ignored bits", {rd_data[4], rd_data[0]}, 2'b00);
      step(SETTLE + 2);

      // R7: release
      phase = "R7";
      wr(8'h0E);
      @(negedge clk);
      check("R7 released", {ee_port_sel, rd_data[4], ee_cs, ee_sk, ee_do}, 0);

      // R2: re-request with port free
      phase = "R2";
      mem_busy = 1'b0;
      wr(8'h22);
      @(negedge clk);
      check("R2 not yet granted", ee_port_sel, 0);
      step(1);
      @(negedge clk);
      check("R2 granted", ee_port_sel, 1);
      step(3);
      finish_run();
   end
endmodule